// File: doc/BRIEF.md
# Host Interrupt Control Register

This block is a byte-wide register on a host I/O bus. It turns status changes from a management microcontroller into one host interrupt line. It watches three sources: the microcontroller's busy bit, its attention bit and a general-purpose request line. A busy bit going from 1 to 0 latches a not-busy event. An attention bit going from 0 to 1 latches an attention event. A high request line latches a general-purpose event. Each event has a flag bit and an enable bit in the register.

The host reads the register to see which events are pending and clears a flag by writing 0 to its bit. Writing 1 to a flag bit leaves that flag as it is, so the host can clear one flag without disturbing the others. The interrupt output is a registered OR over all sources whose flag and enable are both set. When its enable is off, the general-purpose flag can act as a plain status bit.

Top module: `mcu_event_irq_reg`

## Requirements
- R1: The register responds only at address 0x215. A write to any other address changes no enable or flag, and a read at any other address returns 0x00.
- R2: Bits 0, 1 and 2 are read/write enables for the not-busy, attention and general-purpose sources, in that order. 1 means enabled.
- R3: The not-busy flag (bit 4) becomes 1 in the clock edge that sees the busy input at 0 after it was 1 in the previous cycle. A 0-to-1 change of busy does not set it.
- R4: The attention flag (bit 5) becomes 1 in the clock edge that sees the attention input at 1 after it was 0 in the previous cycle. A 1-to-0 change does not set it.
- R5: The general-purpose flag (bit 6) becomes 1 in any clock edge that sees the request input high. With its enable at 0, the flag can be read but does not raise the interrupt.
- R6: A host write at the register address clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1.
- R7: If a source event and a clearing write to its flag happen in the same cycle, the flag ends up set.
- R8: The interrupt output is active high. It equals, one clock later, the OR over sources of (flag AND enable).
- R9: Reserved bits 3 and 7 always read 0, and writing them has no effect.
- R10: Reset clears all enables, all flags and the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Host I/O address |
| busWrEn | input | 1 | Host write strobe, one cycle per write |
| busRdEn | input | 1 | Host read strobe |
| busWrData | input | 8 | Host write data |
| busRdData | output | 8 | Read data; register contents on an address hit, else 0 |
| mcuBusy | input | 1 | Microcontroller busy status bit |
| mcuAttn | input | 1 | Microcontroller attention status bit |
| mcuGpReq | input | 1 | Microcontroller general-purpose request |
| hostIrq | output | 1 | Registered host interrupt, active high |

## Verification
The hardest case to reach is a source edge that lands in the same clock edge as a host write clearing that flag. The ordinary write task cannot line the two up. A dedicated task therefore raises the attention input and drives the clearing write together at one falling edge, and reads the flag back afterwards. The other edge directions are covered by moving each status input both ways and checking that only the intended direction latches a flag.

// File: rtl/mcu_event_irq_pkg.sv
package mcu_event_irq_pkg;

  // number of event sources handled by the register
  localparam int NUM_SRC = 3;

  // source indices: fixed, they select the enable/flag bit positions
  localparam int SRC_NOTBUSY = 0;
  localparam int SRC_ATTN    = 1;
  localparam int SRC_GP      = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic               wrHit;
    logic               rdHit;
    logic [NUM_SRC-1:0] evtSet;
  } ctlStrobe_t;

endpackage

// File: rtl/mcu_event_irq_ctl.sv
module mcu_event_irq_ctl
  import mcu_event_irq_pkg::*;
#(
  parameter int               ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0215
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              mcuBusy,
  input  logic              mcuAttn,
  input  logic              mcuGpReq,
  output ctlStrobe_t        strb
);

  logic addrHit;
  logic busyQ;
  logic attnQ;

  assign addrHit = (busAddr == REG_ADDR);

  // previous-cycle copies of the status bits for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      attnQ <= 1'b0;
    end else begin
      busyQ <= mcuBusy;
      attnQ <= mcuAttn;
    end
  end

  always_comb begin
    strb                     = '0;
    strb.wrHit               = busWrEn & addrHit;
    strb.rdHit               = busRdEn & addrHit;
    strb.evtSet[SRC_NOTBUSY] = busyQ & ~mcuBusy;   // busy 1 -> 0
    strb.evtSet[SRC_ATTN]    = ~attnQ & mcuAttn;   // attention 0 -> 1
    strb.evtSet[SRC_GP]      = mcuGpReq;           // level request
  end

endmodule

// File: rtl/mcu_event_irq_dp.sv
module mcu_event_irq_dp
  import mcu_event_irq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ENA_LSB = 0,
  parameter int FLG_LSB = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic [NUM_SRC-1:0] enaQ,
  output logic [NUM_SRC-1:0] flagQ,
  output logic               hostIrq
);

  logic [DATA_W-1:0] rdByte;
  logic              unusedWrBits;

  // reserved write bits are dropped on purpose
  assign unusedWrBits = ^busWrData;

  always_ff @(posedge clk) begin
    if (!rstN)           enaQ <= '0;
    else if (strb.wrHit) enaQ <= busWrData[ENA_LSB +: NUM_SRC];
  end

  // one flag per source: event set beats write-zero clear
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                                    flagQ[i] <= 1'b0;
      else if (strb.evtSet[i])                      flagQ[i] <= 1'b1;
      else if (strb.wrHit && !busWrData[FLG_LSB+i]) flagQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) hostIrq <= 1'b0;
    else       hostIrq <= |(enaQ & flagQ);
  end

  always_comb begin
    rdByte                     = '0;
    rdByte[ENA_LSB +: NUM_SRC] = enaQ;
    rdByte[FLG_LSB +: NUM_SRC] = flagQ;
    busRdData                  = strb.rdHit ? rdByte : '0;
  end

endmodule

// File: rtl/mcu_event_irq_reg.sv
module mcu_event_irq_reg
  import mcu_event_irq_pkg::*;
#(
  parameter int               ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0215,
  parameter int               DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              mcuBusy,
  input  logic              mcuAttn,
  input  logic              mcuGpReq,
  output logic              hostIrq
);

  ctlStrobe_t         strb;
  logic [NUM_SRC-1:0] enaQ;
  logic [NUM_SRC-1:0] flagQ;

  mcu_event_irq_ctl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .mcuBusy  (mcuBusy),
    .mcuAttn  (mcuAttn),
    .mcuGpReq (mcuGpReq),
    .strb     (strb)
  );

  mcu_event_irq_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .enaQ      (enaQ),
    .flagQ     (flagQ),
    .hostIrq   (hostIrq)
  );

endmodule

// File: rtl/mcu_event_irq_chk.sv
module mcu_event_irq_chk #(
  parameter int               ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0215,
  parameter int               DATA_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busRdData,
  input logic              mcuBusy,
  input logic              mcuAttn,
  input logic              mcuGpReq,
  input logic [2:0]        enaQ,
  input logic [2:0]        flagQ,
  input logic              hostIrq
);

  logic wrHere;
  assign wrHere = busWrEn && (busAddr == REG_ADDR);

  AST_OTHER_ADDR_KEEPS_ENA: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !wrHere) |=> $stable(enaQ)); // R1

  AST_BUSY_FALL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(mcuBusy) && !mcuBusy) |=> flagQ[0]); // R3

  AST_ATTN_RISE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(mcuAttn) && mcuAttn) |=> flagQ[1]); // R4

  AST_GP_REQ_SETS: assert property (@(posedge clk) disable iff (!rstN)
    mcuGpReq |=> flagQ[2]); // R5

  AST_FLAG_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(flagQ) & ~flagQ)) |-> $past(wrHere)); // R6

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (hostIrq == |($past(enaQ) & $past(flagQ)))); // R8

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData[3] == 1'b0) && (busRdData[7] == 1'b0)); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |=> (enaQ == 3'b000) && (flagQ == 3'b000) && !hostIrq); // R10

endmodule

bind mcu_event_irq_reg mcu_event_irq_chk #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busRdData (busRdData),
  .mcuBusy   (mcuBusy),
  .mcuAttn   (mcuAttn),
  .mcuGpReq  (mcuGpReq),
  .enaQ      (enaQ),
  .flagQ     (flagQ),
  .hostIrq   (hostIrq)
);

// File: tb/mcu_event_irq_reg_tb.sv
`timescale 1ns/1ps
module mcu_event_irq_reg_tb;

  localparam logic [15:0] REG_A = 16'h0215;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        mcuBusy = 1'b0;
  logic        mcuAttn = 1'b0;
  logic        mcuGpReq = 1'b0;
  logic        hostIrq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mcu_event_irq_reg u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .mcuBusy(mcuBusy), .mcuAttn(mcuAttn), .mcuGpReq(mcuGpReq),
    .hostIrq(hostIrq)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  // one-cycle write, driven and released on falling edges
  task automatic busWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tReset();
    logic [7:0] d;
    busRead(REG_A, d);
    check("R10 reset value", d, 8'h00);
    check("R10 reset irq", {7'b0, hostIrq}, 8'h00);
  endtask

  task automatic tEnables();
    logic [7:0] d;
    busWrite(REG_A, 8'h07);
    busRead(REG_A, d);
    check("R2 all enables", d, 8'h07);
    busWrite(REG_A, 8'h05);
    busRead(REG_A, d);
    check("R2 enable pattern 101", d, 8'h05);
  endtask

  task automatic tDecode();
    logic [7:0] d;
    busWrite(16'h0216, 8'h02);
    busRead(REG_A, d);
    check("R1 write elsewhere ignored", d, 8'h05);
    busRead(16'h0214, d);
    check("R1 read elsewhere zero", d, 8'h00);
  endtask

  task automatic tReserved();
    logic [7:0] d;
    busWrite(REG_A, 8'h8F);
    busRead(REG_A, d);
    check("R9 reserved bits", d, 8'h07);
  endtask

  task automatic tBusy();
    logic [7:0] d;
    busWrite(REG_A, 8'h70);      // all enables off, flags kept
    @(negedge clk) mcuBusy = 1'b1;
    cycles(2);
    busRead(REG_A, d);
    check("R3 busy rise no flag", d, 8'h70 & 8'h00);
    @(negedge clk) mcuBusy = 1'b0;
    cycles(2);
    busRead(REG_A, d);
    check("R3 busy fall sets bit4", d, 8'h10);
    check("R8 no irq when disabled", {7'b0, hostIrq}, 8'h00);
    busWrite(REG_A, 8'h71);      // enable bit0, write 1 keeps flag
    busRead(REG_A, d);
    check("R6 write one keeps flag", d, 8'h11);
    cycles(1);
    check("R8 irq asserted", {7'b0, hostIrq}, 8'h01);
    busWrite(REG_A, 8'h61);      // clear bit4
    busRead(REG_A, d);
    check("R6 write zero clears", d, 8'h01);
    cycles(1);
    check("R8 irq released", {7'b0, hostIrq}, 8'h00);
  endtask

  task automatic tAttn();
    logic [7:0] d;
    busWrite(REG_A, 8'h00);
    @(negedge clk) mcuAttn = 1'b1;
    cycles(2);
    busRead(REG_A, d);
    check("R4 attn rise sets bit5", d, 8'h20);
    busWrite(REG_A, 8'h00);
    @(negedge clk) mcuAttn = 1'b0;
    cycles(2);
    busRead(REG_A, d);
    check("R4 attn fall no flag", d, 8'h00);
  endtask

  task automatic tGp();
    logic [7:0] d;
    busWrite(REG_A, 8'h00);
    @(negedge clk) mcuGpReq = 1'b1;
    @(negedge clk) mcuGpReq = 1'b0;
    cycles(2);
    busRead(REG_A, d);
    check("R5 gp flag as status", d, 8'h40);
    check("R5 gp no irq when disabled", {7'b0, hostIrq}, 8'h00);
    busWrite(REG_A, 8'h44);
    cycles(1);
    check("R8 gp irq when enabled", {7'b0, hostIrq}, 8'h01);
  endtask

  task automatic tRace();
    logic [7:0] d;
    busWrite(REG_A, 8'h00);
    @(negedge clk);
    busAddr = REG_A; busWrData = 8'h00; busWrEn = 1'b1;
    mcuAttn = 1'b1;              // edge and clear meet at one clock edge
    @(negedge clk);
    busWrEn = 1'b0;
    busRead(REG_A, d);
    check("R7 event beats clear", d, 8'h20);
    @(negedge clk) mcuAttn = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    cycles(3);
    @(negedge clk) rstN = 1'b1;
    tReset();
    tEnables();
    tDecode();
    tReserved();
    tBusy();
    tAttn();
    tGp();
    tRace();
    cycles(2);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule